// File: doc/BRIEF.md
# PCM Highway Time-Slot Assigner

This block places four voice channels onto a framed serial PCM highway. A frame-sync pulse marks the start of each frame. A bit clock paces the data. Each channel has its own transmit slot, its own receive slot and its own bit offset. In its transmit slot, an enabled channel drives its 8-bit sample onto the highway, most significant bit first, and raises a bus-enable strobe. An external buffer uses that strobe to take the bus. In its receive slot, an enabled channel assembles eight bits from the receive line and presents them as a completed byte.

A frame holds from 8 to 256 slots. The length of a frame is set only by the spacing of the sync pulses. The bit clock can run at the data rate, or at twice the data rate, in which case each bit lasts two clocks. The transmit and receive lines may be separate (four-wire). They may also be strapped together off-chip (two-wire), in which case a channel ignores the slot it is itself driving. Each channel can also be switched to loopback: it then transmits the last byte it received in place of its own sample.

Top module: `pcm_slot_assigner`

## Requirements
- R1: While reset is held, and after it until the first frame sync, `pcm_tx_en`, `pcm_tx` and `slot_conflict` are 0. `rx_sample` is all zeros and `rx_done` is all zeros. No slot is active before the first frame sync.
- R2: Define frame bit n as the n-th bit period after the rising clock edge at which `frame_sync` is sampled high (n = 0 is the period that starts at that edge). During frame bit n, an enabled channel whose transmit slot equals (n - offset) / 8 drives `pcm_tx_en` = 1. It also drives `pcm_tx` = bit 7 - ((n - offset) mod 8) of its sample, so the MSB is sent first.
- R3: During frame bit n, a channel whose receive slot equals (n - offset) / 8 samples `pcm_rx` on the falling clock edge. At the rising edge that ends the eighth bit, the channel loads `rx_sample` with the byte, first bit as MSB. It also pulses its `rx_done` bit for exactly one clock.
- R4: Each channel's 3-bit `bit_offset` field delays both its transmit slot and its receive slot by that many bit periods. The delay applies to that channel only.
- R5: With `dbl_clk_mode` = 1, each bit period lasts two clocks and the bit counter advances every second clock. `frame_sync` restarts the clock phase.
- R6: When no enabled channel owns the current transmit bit, `pcm_tx_en` = 0 and `pcm_tx` = 0.
- R7: When several enabled channels own the same transmit bit, the lowest-numbered of them drives the data, and `slot_conflict` is 1 for exactly those bits.
- R8: A channel with `tx_enable` = 0 never drives the highway. A channel with `rx_enable` = 0 leaves its `rx_sample` and `rx_done` unchanged.
- R9: With `two_wire_mode` = 1, a channel does not capture during a bit in which it is itself transmitting. It still captures slots driven by other channels.
- R10: With its `loop_enable` bit = 1, a channel transmits its current `rx_sample` in place of its `tx_sample`.
- R11: Slots 0 to 255 are reachable, and any frame length from 8 to 256 slots works. Each `frame_sync` restarts the bit count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Highway bit clock; data is launched on the rising edge and sampled on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Frame-sync pulse, one clock wide, sampled on the rising edge |
| dbl_clk_mode | input | 1 | 1: the bit clock runs at twice the data rate |
| two_wire_mode | input | 1 | 1: the receive line is strapped to the transmit line |
| tx_enable | input | 4 | Per-channel transmit enable |
| rx_enable | input | 4 | Per-channel receive enable |
| loop_enable | input | 4 | Per-channel digital loopback |
| tx_slot | input | 32 | Transmit slot number, 8 bits per channel, channel 0 in the low byte |
| rx_slot | input | 32 | Receive slot number, 8 bits per channel, channel 0 in the low byte |
| bit_offset | input | 12 | Bit offset, 3 bits per channel, channel 0 in the low bits |
| tx_sample | input | 32 | Sample to transmit, 8 bits per channel |
| pcm_rx | input | 1 | Receive data line |
| pcm_tx | output | 1 | Transmit data line, 0 when not driving |
| pcm_tx_en | output | 1 | Bus-enable strobe for the external driver |
| slot_conflict | output | 1 | More than one enabled channel owns the current transmit bit |
| rx_sample | output | 32 | Last completed received byte, 8 bits per channel |
| rx_done | output | 4 | One-clock pulse per channel when a byte completes |

## Verification
Two kinds of collision are provoked.

The first happens in two-wire mode. A channel's receive slot is placed on its own transmit slot, and a second channel's receive slot is placed on a third channel's transmit slot. In the same bit times, the highway then carries a byte that one channel must skip and another must capture. Each frame, the bench compares the skipping channel's unchanged byte and the capturing channel's copy of the sibling sample.

The second happens in loopback. The receive slot completes before the transmit slot, so the byte that finishes at a rising edge is the one driven in the later slot. A behavioural model tracks both effects every clock and judges the highway, the strobe, the conflict flag and every received byte against them.

// File: rtl/pcm_tsa_pkg.sv
// Shared constants for the PCM time-slot assigner.
// Assumes 8-bit samples; every slot is one sample wide.
package pcm_tsa_pkg;
    localparam int SAMPLE_BITS = 8;
    localparam int IDX_W       = $clog2(SAMPLE_BITS);
endpackage

// File: rtl/pcm_frame_timer.sv
// Frame bit counter for the highway.
// A sampled frame_sync zeroes the count and the half-rate phase. The count then advances once
// per data bit: every clock in single-rate mode, every second clock in double-rate mode. It
// saturates at all ones, which the slot decoders treat as "no slot", so nothing is active
// before the first sync. Assumes sync comes once per frame, on the edge that ends the last bit.
module pcm_frame_timer import pcm_tsa_pkg::*; #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             dbl,
    output logic             tick,
    output logic [CNT_W-1:0] bit_cnt
);
    logic phase;

    // A data bit ends on this clock edge.
    assign tick = !dbl || phase;

    // Count data bits since the last sync; keep the half-rate phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '1;
            phase   <= 1'b0;
        end else if (fsync) begin
            bit_cnt <= '0;
            phase   <= 1'b0;
        end else begin
            phase <= dbl ? !phase : 1'b0;
            if (tick && (bit_cnt != '1)) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    a_r11_sync_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (bit_cnt == '0));
    a_r5_count_waits_half_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !fsync) |=> $stable(bit_cnt));
endmodule

// File: rtl/pcm_slot_match.sv
// Decides whether the current frame bit falls inside a given slot, after removing this
// channel's bit offset, and gives the bit's position within that slot.
// Assumes the frame holds at most 2**SLOT_W slots.
module pcm_slot_match import pcm_tsa_pkg::*; #(
    parameter int CNT_W  = 12,
    parameter int SLOT_W = 8,
    parameter int OFS_W  = 3
) (
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [OFS_W-1:0]  offset,
    input  logic [SLOT_W-1:0] slot,
    output logic              hit,
    output logic [IDX_W-1:0]  bit_idx
);
    localparam int               FRAME_BITS = (1 << SLOT_W) * SAMPLE_BITS;
    localparam logic [CNT_W-1:0] FRAME_LIM  = CNT_W'(FRAME_BITS);

    logic [CNT_W-1:0] shifted;
    logic             started;

    // Position in the frame with this channel's offset taken out.
    always_comb begin
        started = bit_cnt >= CNT_W'(offset);
        shifted = bit_cnt - CNT_W'(offset);
        bit_idx = shifted[IDX_W-1:0];
        hit     = started && (shifted < FRAME_LIM)
                  && (shifted[IDX_W +: SLOT_W] == slot);
    end
endmodule

// File: rtl/pcm_rx_lane.sv
// Receive assembler for one channel.
// Shifts in one sampled bit per data bit while capture is allowed. After the final bit of the
// slot it loads the whole byte and pulses done. Assumes din was sampled on the falling edge
// within the bit.
module pcm_rx_lane import pcm_tsa_pkg::*; (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   capture,
    input  logic [IDX_W-1:0]       bit_idx,
    input  logic                   din,
    output logic [SAMPLE_BITS-1:0] data,
    output logic                   done
);
    logic [SAMPLE_BITS-2:0] shreg;
    logic                   last_bit;

    assign last_bit = (bit_idx == IDX_W'(SAMPLE_BITS - 1));

    // Shift bits in MSB first and complete the byte on the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            data  <= '0;
            done  <= 1'b0;
        end else begin
            done <= tick && capture && last_bit;
            if (tick && capture) begin
                shreg <= {shreg[SAMPLE_BITS-3:0], din};
                if (last_bit) data <= {shreg, din};
            end
        end
    end

    a_r8_byte_held_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(data));
    a_r3_done_is_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/pcm_tx_select.sv
// Transmit arbiter for the highway.
// Among the channels that own the current bit, the lowest-numbered one wins. The winner's
// sample bit goes out MSB first. The data line stays 0 while nobody drives, and the conflict
// flag marks bits with more than one owner.
module pcm_tx_select import pcm_tsa_pkg::*; #(
    parameter int NCH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             own,
    input  logic [NCH*IDX_W-1:0]       bit_idx,
    input  logic [NCH*SAMPLE_BITS-1:0] data,
    output logic                       drive,
    output logic                       dout,
    output logic                       conflict
);
    logic [SAMPLE_BITS-1:0] sel_byte;
    logic [IDX_W-1:0]       sel_bit;

    // Pick the lowest owning channel and count the owners.
    always_comb begin
        int win;
        int owners;
        win    = 0;
        owners = 0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (own[i]) begin
                win    = i;
                owners = owners + 1;
            end
        end
        sel_byte = data[win*SAMPLE_BITS +: SAMPLE_BITS];
        sel_bit  = bit_idx[win*IDX_W +: IDX_W];
        drive    = owners > 0;
        conflict = owners > 1;
        dout     = drive && sel_byte[IDX_W'(SAMPLE_BITS - 1) - sel_bit];
    end

    a_r6_line_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> !dout);
    a_r7_conflict_only_when_owned: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> ($countones(own) > 1));
endmodule

// File: rtl/pcm_slot_assigner.sv
// Four-channel PCM time-slot assigner.
// Connects NCH channels to a framed serial highway. Each channel has a transmit slot, a
// receive slot and a bit offset, and can be set to loopback. Data leaves on the rising edge
// and is sampled on the falling edge. Assumes every configured slot, plus its offset, ends
// inside the frame, and that configuration is held steady while a frame runs.
module pcm_slot_assigner import pcm_tsa_pkg::*; #(
    parameter int NCH    = 4,
    parameter int SLOT_W = 8,
    parameter int OFS_W  = 3
) (
    input  logic                       bit_clk,
    input  logic                       rst_n,
    input  logic                       frame_sync,
    input  logic                       dbl_clk_mode,
    input  logic                       two_wire_mode,
    input  logic [NCH-1:0]             tx_enable,
    input  logic [NCH-1:0]             rx_enable,
    input  logic [NCH-1:0]             loop_enable,
    input  logic [NCH*SLOT_W-1:0]      tx_slot,
    input  logic [NCH*SLOT_W-1:0]      rx_slot,
    input  logic [NCH*OFS_W-1:0]       bit_offset,
    input  logic [NCH*SAMPLE_BITS-1:0] tx_sample,
    input  logic                       pcm_rx,
    output logic                       pcm_tx,
    output logic                       pcm_tx_en,
    output logic                       slot_conflict,
    output logic [NCH*SAMPLE_BITS-1:0] rx_sample,
    output logic [NCH-1:0]             rx_done
);
    localparam int CNT_W = SLOT_W + IDX_W + 1;

    logic                       tick;
    logic [CNT_W-1:0]           bit_cnt;
    logic                       rx_bit_smp;
    logic [NCH-1:0]             tx_hit;
    logic [NCH-1:0]             rx_hit;
    logic [NCH-1:0]             tx_own;
    logic [NCH*IDX_W-1:0]       tx_idx;
    logic [NCH*IDX_W-1:0]       rx_idx;
    logic [NCH*SAMPLE_BITS-1:0] tx_src;

    // Sample the receive line in the middle of the bit.
    always_ff @(negedge bit_clk) begin
        if (!rst_n) rx_bit_smp <= 1'b0;
        else        rx_bit_smp <= pcm_rx;
    end

    pcm_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (bit_clk),
        .rst_n   (rst_n),
        .fsync   (frame_sync),
        .dbl     (dbl_clk_mode),
        .tick    (tick),
        .bit_cnt (bit_cnt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic capture;

        pcm_slot_match #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .OFS_W(OFS_W)) u_tx_match (
            .bit_cnt (bit_cnt),
            .offset  (bit_offset[g*OFS_W +: OFS_W]),
            .slot    (tx_slot[g*SLOT_W +: SLOT_W]),
            .hit     (tx_hit[g]),
            .bit_idx (tx_idx[g*IDX_W +: IDX_W])
        );

        pcm_slot_match #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .OFS_W(OFS_W)) u_rx_match (
            .bit_cnt (bit_cnt),
            .offset  (bit_offset[g*OFS_W +: OFS_W]),
            .slot    (rx_slot[g*SLOT_W +: SLOT_W]),
            .hit     (rx_hit[g]),
            .bit_idx (rx_idx[g*IDX_W +: IDX_W])
        );

        // A channel owns the bit only while its transmitter is enabled.
        assign tx_own[g] = tx_enable[g] && tx_hit[g];
        // Loopback sends the last received byte in place of the local sample.
        assign tx_src[g*SAMPLE_BITS +: SAMPLE_BITS] = loop_enable[g]
            ? rx_sample[g*SAMPLE_BITS +: SAMPLE_BITS]
            : tx_sample[g*SAMPLE_BITS +: SAMPLE_BITS];
        // On a strapped bus a channel must not hear itself.
        assign capture = rx_enable[g] && rx_hit[g] && !(two_wire_mode && tx_own[g]);

        pcm_rx_lane u_lane (
            .clk     (bit_clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .capture (capture),
            .bit_idx (rx_idx[g*IDX_W +: IDX_W]),
            .din     (rx_bit_smp),
            .data    (rx_sample[g*SAMPLE_BITS +: SAMPLE_BITS]),
            .done    (rx_done[g])
        );

        a_r9_own_slot_not_heard: assert property (@(posedge bit_clk) disable iff (!rst_n)
            (two_wire_mode && tx_own[g] && rx_hit[g]) |=> $stable(rx_sample[g*SAMPLE_BITS +: SAMPLE_BITS]));
        a_r8_disabled_rx_silent: assert property (@(posedge bit_clk) disable iff (!rst_n)
            !rx_enable[g] |=> !rx_done[g]);
    end

    pcm_tx_select #(.NCH(NCH)) u_tx_sel (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .own      (tx_own),
        .bit_idx  (tx_idx),
        .data     (tx_src),
        .drive    (pcm_tx_en),
        .dout     (pcm_tx),
        .conflict (slot_conflict)
    );

    a_r8_strobe_needs_enable: assert property (@(posedge bit_clk) disable iff (!rst_n)
        pcm_tx_en |-> (tx_enable != '0));
    a_r1_idle_after_reset: assert property (@(posedge bit_clk)
        !rst_n |=> (!pcm_tx_en && (rx_done == '0)));
endmodule

// File: tb/pcm_slot_assigner_tb.sv
`timescale 1ns/1ps
module pcm_slot_assigner_tb;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        dbl_clk_mode = 1'b0;
    logic        two_wire_mode = 1'b0;
    logic [3:0]  tx_enable = '0, rx_enable = '0, loop_enable = '0;
    logic [31:0] tx_slot = '0, rx_slot = '0, tx_sample = '0;
    logic [11:0] bit_offset = '0;
    logic        ext_rx = 1'b0;
    logic        rx_line;
    logic        pcm_tx, pcm_tx_en, slot_conflict;
    logic [31:0] rx_sample;
    logic [3:0]  rx_done;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    chk_on   = 0;
    bit    finished = 0;
    string cur_tag  = "R1";

    always #4 clk = ~clk;

    // Off-chip strap for the two-wire bus.
    assign rx_line = (two_wire_mode && pcm_tx_en) ? pcm_tx : ext_rx;

    pcm_slot_assigner u_dut (
        .bit_clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .dbl_clk_mode(dbl_clk_mode), .two_wire_mode(two_wire_mode),
        .tx_enable(tx_enable), .rx_enable(rx_enable), .loop_enable(loop_enable),
        .tx_slot(tx_slot), .rx_slot(rx_slot), .bit_offset(bit_offset),
        .tx_sample(tx_sample), .pcm_rx(rx_line), .pcm_tx(pcm_tx),
        .pcm_tx_en(pcm_tx_en), .slot_conflict(slot_conflict),
        .rx_sample(rx_sample), .rx_done(rx_done)
    );

    // ---------------- behavioural reference model ----------------
    int       m_fc;
    bit       m_ph;
    bit       m_smp;
    bit [6:0] m_sh [NCH];
    bit [7:0] m_rd [NCH];
    bit       m_stb[NCH];

    function automatic bit in_slot(int fc, int ofs, int slot, output int bi);
        int e;
        e  = fc - ofs;
        bi = ((e % 8) + 8) % 8;
        return (fc >= ofs) && (e < 2048) && ((e / 8) == slot);
    endfunction

    always @(negedge clk) m_smp = rx_line;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fc = 4095; m_ph = 0;
            for (int c = 0; c < NCH; c++) begin m_sh[c] = 0; m_rd[c] = 0; m_stb[c] = 0; end
        end else begin
            bit tk;
            tk = !dbl_clk_mode || m_ph;
            for (int c = 0; c < NCH; c++) begin
                int  rb, tb;
                bit  rh, th;
                rh = in_slot(m_fc, int'(bit_offset[c*3 +: 3]), int'(rx_slot[c*8 +: 8]), rb);
                th = in_slot(m_fc, int'(bit_offset[c*3 +: 3]), int'(tx_slot[c*8 +: 8]), tb);
                m_stb[c] = 0;
                if (tk && rx_enable[c] && rh && !(two_wire_mode && tx_enable[c] && th)) begin
                    if (rb == 7) begin m_rd[c] = {m_sh[c], m_smp}; m_stb[c] = 1; end
                    m_sh[c] = {m_sh[c][5:0], m_smp};
                end
            end
            if (frame_sync) begin m_fc = 0; m_ph = 0; end
            else begin
                m_ph = dbl_clk_mode ? !m_ph : 1'b0;
                if (tk && m_fc < 4095) m_fc = m_fc + 1;
            end
        end
    end

    // Compare every clock, one time unit before the next rising edge.
    always @(posedge clk) begin
        #7;
        if (chk_on) begin
            int  owners, win, wbit;
            bit  e_oe, e_out, e_conf;
            bit [7:0] src;
            bit [31:0] e_rx;
            bit [3:0]  e_dn;
            string t;
            owners = 0; win = 0; wbit = 0;
            for (int c = NCH - 1; c >= 0; c--) begin
                int bi;
                if (tx_enable[c] && in_slot(m_fc, int'(bit_offset[c*3 +: 3]), int'(tx_slot[c*8 +: 8]), bi)) begin
                    owners++; win = c; wbit = bi;
                end
            end
            src    = loop_enable[win] ? m_rd[win] : tx_sample[win*8 +: 8];
            e_oe   = owners > 0;
            e_conf = owners > 1;
            e_out  = e_oe && src[7 - wbit];
            for (int c = 0; c < NCH; c++) begin e_rx[c*8 +: 8] = m_rd[c]; e_dn[c] = m_stb[c]; end
            t = !e_oe ? "R6" : (e_conf ? "R7" : (loop_enable[win] ? "R10" : "R2"));
            n_checks++;
            if ({pcm_tx_en, pcm_tx, slot_conflict} !== {e_oe, e_out, e_conf}) begin
                n_fails++;
                $display("FAIL %s/%s highway: actual oe=%b tx=%b conf=%b expected oe=%b tx=%b conf=%b @%0t",
                         cur_tag, t, pcm_tx_en, pcm_tx, slot_conflict, e_oe, e_out, e_conf, $time);
            end
            n_checks++;
            if (rx_sample !== e_rx || rx_done !== e_dn) begin
                n_fails++;
                $display("FAIL %s/R3 receive: actual %h/%b expected %h/%b @%0t",
                         cur_tag, rx_sample, rx_done, e_rx, e_dn, $time);
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk); #1;
    endtask

    // One sync pulse, then idle until the frame begins.
    task automatic sync_pulse();
        cycle(); frame_sync = 1'b1;
        cycle(); frame_sync = 1'b0;
    endtask

    // Run one frame of nbits data bits; the sync for the next frame ends it.
    task automatic run_frame(int nbits);
        int clocks;
        clocks = nbits * (dbl_clk_mode ? 2 : 1);
        for (int c = 0; c < clocks; c++) begin
            frame_sync = (c == clocks - 1);
            ext_rx     = 1'($urandom);
            cycle();
        end
        frame_sync = 1'b0;
    endtask

    task automatic set_chan(int c, int ts, int rs, int ofs);
        tx_slot[c*8 +: 8]    = 8'(ts);
        rx_slot[c*8 +: 8]    = 8'(rs);
        bit_offset[c*3 +: 3] = 3'(ofs);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        tx_sample = {8'h5E, 8'h81, 8'h3C, 8'hA5};
        repeat (4) cycle();
        chk_on = 1;
        // R1: reset outputs
        check("R1 reset", {pcm_tx_en, pcm_tx, slot_conflict, rx_done, rx_sample[27:0]}, 32'h0);
        rst_n = 1'b1;
        tx_enable = 4'hF; rx_enable = 4'hF;
        set_chan(0, 0, 3, 0); set_chan(1, 5, 5, 1); set_chan(2, 30, 20, 3); set_chan(3, 12, 29, 7);
        // R1 / R11: nothing active before the first sync
        cur_tag = "R11";
        repeat (20) begin cycle(); check("R1 no slot before sync", {31'h0, pcm_tx_en}, 32'h0); end

        // R2, R3, R4: 32-slot frames, four-wire, mixed offsets
        cur_tag = "R4";
        sync_pulse();
        repeat (3) run_frame(256);

        // R11: 256-slot frame, last slot reachable
        cur_tag = "R11";
        set_chan(2, 255, 254, 0); set_chan(3, 1, 255, 0);
        run_frame(2048);
        // R11: shortest frame
        set_chan(0, 7, 0, 0); set_chan(1, 3, 6, 0); set_chan(2, 0, 7, 0); set_chan(3, 5, 2, 0);
        repeat (3) run_frame(64);

        // R7: shared transmit slot
        cur_tag = "R7";
        set_chan(0, 0, 4, 0); set_chan(1, 2, 6, 0); set_chan(2, 9, 9, 0); set_chan(3, 2, 11, 0);
        repeat (2) run_frame(128);

        // R8: disabled transmitter and receiver
        cur_tag = "R8";
        tx_enable = 4'b1101; rx_enable = 4'b1110;
        held = rx_sample[7:0];
        repeat (2) run_frame(128);
        check("R8 rx disabled byte unchanged", {24'h0, rx_sample[7:0]}, {24'h0, held});
        tx_enable = 4'hF; rx_enable = 4'hF;

        // R5: double-rate clock
        cur_tag = "R5";
        dbl_clk_mode = 1'b1;
        set_chan(0, 1, 2, 2); set_chan(1, 4, 1, 5); set_chan(2, 6, 6, 0); set_chan(3, 2, 7, 3);
        repeat (3) run_frame(128);
        dbl_clk_mode = 1'b0;

        // R9: strapped bus; ch0 hears its own slot (skip), ch1 hears ch2
        cur_tag = "R9";
        two_wire_mode = 1'b1;
        set_chan(0, 4, 4, 0); set_chan(1, 10, 6, 0); set_chan(2, 6, 13, 0); set_chan(3, 12, 2, 0);
        held = rx_sample[7:0];
        repeat (2) run_frame(128);
        check("R9 own slot not captured", {24'h0, rx_sample[7:0]}, {24'h0, held});
        check("R9 sibling slot captured", {24'h0, rx_sample[15:8]}, 32'h81);
        two_wire_mode = 1'b0;

        // R10: loopback, received slot precedes the transmit slot
        cur_tag = "R10";
        loop_enable = 4'b0010;
        set_chan(1, 9, 3, 0);
        repeat (3) run_frame(128);
        loop_enable = 4'b0000;

        cur_tag = "R1";
        repeat (3) cycle();
        finished = 1;
        summary();
        $finish;
    end
endmodule